// File: doc/BRIEF.md
# Framed Serial Result Transmitter

This block sends a 14-bit two's complement conversion result over a three-wire serial link made of a serial clock, a data line and an active-low frame strobe. The serial clock is the converter clock divided by two. Each output has its own output enable, so the pads can be tri-stated when they are not in use. A frame starts on a rising serial clock edge. The strobe goes low and the most significant bit is put on the data line. The receiver captures each bit on the following falling serial clock edge. Data moves on to the next bit at every rising edge, and the frame closes at the rising edge after the fourteenth bit.

A mode input sets how the serial clock behaves. In free-running mode the clock and the strobe are driven all the time, and the clock toggles on every converter clock cycle. In gated mode the clock and the strobe are driven only during a frame and are released to high impedance otherwise. A result-ready pulse that arrives while a frame is in progress is stored and sent once the current frame has ended. If several pulses arrive, the most recent word is the one sent.

Top module: `ser_frame_tx`

## Requirements
- R1: During and right after synchronous reset in gated mode (`clk_mode`=0): `sclk`=0, `strobe_n`=1, and `sclk_oe`, `strobe_oe` and `sdata_oe` are all 0.
- R2: With `clk_mode`=1 (free-running), `sclk_oe` stays 1 and `sclk` changes level on every `clk` cycle, both inside and outside frames.
- R3: With `clk_mode`=0 (gated), `sclk_oe` is 1 only while a frame is active (`strobe_n`=0) and is 0 at all other times.
- R4: Each frame holds `strobe_n` low for exactly 28 `clk` cycles, which is 14 serial clock periods.
- R5: Each frame carries exactly 14 bits, sampled at the falling edges of `sclk`. The bits come out in order from bit 13 (the sign bit) down to bit 0, and the captured word equals the `result` that was latched.
- R6: Inside a frame, `sdata` changes only when `sclk` rises.
- R7: `sdata_oe` is 1 exactly while `strobe_n` is low, so the data line is tri-stated whenever no frame is active.
- R8: A `rdy` pulse that arrives during a frame does not disturb that frame. Its word is sent in the next frame, after `strobe_n` has been high for at least one cycle. When several pulses arrive, the last word wins.
- R9: From idle, the frame strobe falls no later than the third `clk` falling edge after the `clk` edge that samples `rdy`.
- R10: `strobe_n` is low for at least one `clk` cycle before the first falling `sclk` edge of the frame. At the point where the strobe falls, `sclk` is high.
- R11: `strobe_oe` always equals `sclk_oe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock; `sclk` is this clock divided by two |
| rst | input | 1 | Synchronous active-high reset |
| rdy | input | 1 | One-cycle pulse: a new result is present on `result` |
| result | input | 14 | Two's complement conversion result |
| clk_mode | input | 1 | 1 = free-running serial clock, 0 = gated serial clock |
| sclk | output | 1 | Serial clock level |
| sclk_oe | output | 1 | Drive enable for `sclk` |
| sdata | output | 1 | Serial data, valid at falling `sclk` while the strobe is low |
| sdata_oe | output | 1 | Drive enable for `sdata` |
| strobe_n | output | 1 | Active-low frame strobe |
| strobe_oe | output | 1 | Drive enable for `strobe_n` |

## Verification
The assertions assume that `clk_mode` changes only while no frame is active, and that `result` is valid in the cycle where `rdy` is high. The bench changes the mode only between scenarios, after every frame in flight has ended. It drives `rdy` and `result` together for a single cycle, at a falling clock edge. Pulses that land inside a frame are timed from the observed fall of the strobe, so the hold-and-replace behaviour is exercised without ever changing the mode in the middle of a frame.

// File: rtl/sft_pkg.sv
package sft_pkg;

    typedef enum logic {
        SCK_GATED = 1'b0,
        SCK_FREE  = 1'b1
    } sck_mode_e;

    typedef struct packed {
        logic launch;
        logic advance;
        logic finish;
    } seq_ctl_t;

    function automatic int idx_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sft_phase.sv
module sft_phase (
    input  logic clk,
    input  logic rst,
    output logic phase,
    output logic rise_next
);
    always_ff @(posedge clk) begin
        if (rst) phase <= 1'b0;
        else     phase <= ~phase;
    end

    assign rise_next = ~phase;
endmodule

// File: rtl/sft_hold.sv
module sft_hold #(
    parameter int WORD_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              take,
    output logic              pend,
    output logic [WORD_W-1:0] pend_word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b0;
            pend_word <= '0;
        end else begin
            if (in_valid) begin
                pend      <= 1'b1;
                pend_word <= in_word;
            end else if (take) begin
                pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sft_seq.sv
module sft_seq
    import sft_pkg::*;
#(
    parameter int WORD_W = 14
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     pend,
    output seq_ctl_t ctl,
    output logic     busy
);
    localparam int CW = idx_width(WORD_W);
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

    logic [CW-1:0] bit_idx;

    always_comb begin
        ctl.launch  = tick & ~busy & pend;
        ctl.advance = tick & busy & (bit_idx != LAST);
        ctl.finish  = tick & busy & (bit_idx == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            bit_idx <= '0;
        end else begin
            if (ctl.launch) begin
                busy    <= 1'b1;
                bit_idx <= '0;
            end else if (ctl.finish) begin
                busy <= 1'b0;
            end else if (ctl.advance) begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sft_shift.sv
module sft_shift #(
    parameter int WORD_W    = 14,
    parameter bit MSB_FIRST = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  logic [WORD_W-1:0] word,
    output logic              bit_out
);
    logic [WORD_W-1:0] shreg;

    generate
        if (MSB_FIRST) begin : g_msb
            always_ff @(posedge clk) begin
                if (rst)          shreg <= '0;
                else if (load)    shreg <= word;
                else if (advance) shreg <= {shreg[WORD_W-2:0], 1'b0};
            end
            assign bit_out = shreg[WORD_W-1];
        end else begin : g_lsb
            always_ff @(posedge clk) begin
                if (rst)          shreg <= '0;
                else if (load)    shreg <= word;
                else if (advance) shreg <= {1'b0, shreg[WORD_W-1:1]};
            end
            assign bit_out = shreg[0];
        end
    endgenerate
endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx
    import sft_pkg::*;
#(
    parameter int WORD_W    = 14,
    parameter bit MSB_FIRST = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rdy,
    input  logic [WORD_W-1:0] result,
    input  logic              clk_mode,
    output logic              sclk,
    output logic              sclk_oe,
    output logic              sdata,
    output logic              sdata_oe,
    output logic              strobe_n,
    output logic              strobe_oe
);
    logic              phase;
    logic              rise_next;
    logic              pend;
    logic [WORD_W-1:0] pend_word;
    seq_ctl_t          ctl;
    logic              busy;
    logic              tx_bit;

    sft_phase u_phase (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .rise_next (rise_next)
    );

    sft_hold #(.WORD_W(WORD_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (rdy),
        .in_word   (result),
        .take      (ctl.launch),
        .pend      (pend),
        .pend_word (pend_word)
    );

    sft_seq #(.WORD_W(WORD_W)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .tick (rise_next),
        .pend (pend),
        .ctl  (ctl),
        .busy (busy)
    );

    sft_shift #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (ctl.launch),
        .advance (ctl.advance),
        .word    (pend_word),
        .bit_out (tx_bit)
    );

    logic drive_clk;
    assign drive_clk = (sck_mode_e'(clk_mode) == SCK_FREE) | busy;

    assign sclk      = phase;
    assign sclk_oe   = drive_clk;
    assign strobe_n  = ~busy;
    assign strobe_oe = drive_clk;
    assign sdata     = busy & tx_bit;
    assign sdata_oe  = busy;
endmodule

// File: rtl/ser_frame_tx_chk.sv
module ser_frame_tx_chk #(
    parameter int WORD_W = 14
) (
    input logic clk,
    input logic rst,
    input logic clk_mode,
    input logic sclk,
    input logic sclk_oe,
    input logic sdata,
    input logic sdata_oe,
    input logic strobe_n,
    input logic strobe_oe
);
    localparam int FRAME_CYC = 2 * WORD_W;
    localparam int LW = $clog2(FRAME_CYC + 2);

    logic [LW-1:0] low_len;

    always_ff @(posedge clk) begin
        if (rst)            low_len <= '0;
        else if (!strobe_n) low_len <= low_len + 1'b1;
        else                low_len <= '0;
    end

    AST_FREE_DRIVE: assert property (@(posedge clk) disable iff (rst)
        clk_mode |-> sclk_oe); // R2

    AST_FREE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        clk_mode |=> (sclk != $past(sclk))); // R2

    AST_GATED_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!clk_mode && strobe_n) |-> !sclk_oe); // R3

    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_n) |-> (low_len == LW'(FRAME_CYC))); // R4

    AST_DATA_STEADY: assert property (@(posedge clk) disable iff (rst)
        (sdata_oe && $past(sdata_oe) && !$rose(sclk)) |-> $stable(sdata)); // R6

    AST_DATA_TRI: assert property (@(posedge clk) disable iff (rst)
        sdata_oe == !strobe_n); // R7

    AST_LEAD_HIGH: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe_n) |-> sclk); // R10

    AST_OE_PAIR: assert property (@(posedge clk) disable iff (rst)
        strobe_oe == sclk_oe); // R11
endmodule

bind ser_frame_tx ser_frame_tx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clk_mode  (clk_mode),
    .sclk      (sclk),
    .sclk_oe   (sclk_oe),
    .sdata     (sdata),
    .sdata_oe  (sdata_oe),
    .strobe_n  (strobe_n),
    .strobe_oe (strobe_oe)
);

// File: tb/ser_frame_tx_bench.sv
`timescale 1ns/1ps
module ser_frame_tx_bench;
    localparam int W = 14;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rdy = 1'b0;
    logic [W-1:0] result = '0;
    logic         clk_mode = 1'b0;
    logic sclk, sclk_oe, sdata, sdata_oe, strobe_n, strobe_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ser_frame_tx #(.WORD_W(W)) u_ser_frame_tx (
        .clk(clk), .rst(rst), .rdy(rdy), .result(result), .clk_mode(clk_mode),
        .sclk(sclk), .sclk_oe(sclk_oe), .sdata(sdata), .sdata_oe(sdata_oe),
        .strobe_n(strobe_n), .strobe_oe(strobe_oe)
    );

    // frame monitor
    logic [W-1:0] fword [0:15];
    int fbits [0:15];
    int flen  [0:15];
    int flead [0:15];
    int fgap  [0:15];
    int nframes = 0;
    bit in_frame = 0, seen_fall = 0, prev_act = 0;
    logic prev_sclk = 0, prev_sdata = 0;
    logic [W-1:0] cur_word;
    int cur_bits, cur_len, cur_lead, cur_gap, idle_cnt = 1000;
    int err_oe = 0, err_chg = 0, err_gate = 0, err_free = 0, err_pair = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (strobe_oe && !strobe_n) begin
                if (!in_frame) begin
                    in_frame = 1; seen_fall = 0;
                    cur_word = '0; cur_bits = 0; cur_len = 0; cur_lead = 0;
                    cur_gap = idle_cnt;
                end
                cur_len++;
                if (prev_sclk && !sclk) begin
                    cur_word = {cur_word[W-2:0], sdata};
                    cur_bits++; seen_fall = 1;
                end else if (!seen_fall) cur_lead++;
                if (sdata_oe !== 1'b1) err_oe++;
                if (prev_act && !(!prev_sclk && sclk) && sdata !== prev_sdata) err_chg++;
                prev_act = 1;
            end else begin
                if (in_frame && nframes < 16) begin
                    fword[nframes] = cur_word; fbits[nframes] = cur_bits;
                    flen[nframes] = cur_len; flead[nframes] = cur_lead;
                    fgap[nframes] = cur_gap; nframes++;
                end
                if (in_frame) idle_cnt = 0;
                in_frame = 0; prev_act = 0;
                idle_cnt++;
                if (sdata_oe !== 1'b0) err_oe++;
                if (!clk_mode && sclk_oe !== 1'b0) err_gate++;
            end
            if (clk_mode && (sclk_oe !== 1'b1 || sclk === prev_sclk)) err_free++;
            if (strobe_oe !== sclk_oe) err_pair++;
        end
        prev_sclk = sclk;
        prev_sdata = sdata;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_errs();
        err_oe = 0; err_chg = 0; err_gate = 0; err_free = 0; err_pair = 0;
    endtask

    task automatic pulse(input logic [W-1:0] w);
        @(negedge clk); rdy = 1'b1; result = w;
        @(negedge clk); rdy = 1'b0; result = '0;
    endtask

    task automatic wait_frames(input int n);
        for (int i = 0; i < 400 && nframes < n; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; clk_mode = 1'b0;
        repeat (3) @(negedge clk);
        check(sclk === 0 && strobe_n === 1, "R1 reset levels", {sclk, strobe_n}, 2'b01);
        check({sclk_oe, strobe_oe, sdata_oe} === 3'b000, "R1 reset enables",
              {sclk_oe, strobe_oe, sdata_oe}, 0);
        rst = 1'b0;
        @(negedge clk);
        check({sclk_oe, strobe_oe, sdata_oe} === 3'b000, "R1 after release",
              {sclk_oe, strobe_oe, sdata_oe}, 0);
    endtask

    task automatic t_word(input logic [W-1:0] w);
        int base = nframes;
        clear_errs();
        pulse(w);
        wait_frames(base + 1);
        check(fword[base] === w, "R5 word", fword[base], w);
        check(fbits[base] == W, "R5 bit count", fbits[base], W);
        check(flen[base] == 2 * W, "R4 strobe length", flen[base], 2 * W);
        check(flead[base] >= 1, "R10 strobe lead", flead[base], 1);
        check(err_oe == 0, "R7 data enable", err_oe, 0);
        check(err_chg == 0, "R6 data change", err_chg, 0);
        check(err_gate == 0, "R3 gated idle clock", err_gate, 0);
        check(err_pair == 0, "R11 enable pair", err_pair, 0);
    endtask

    task automatic t_latency();
        int n = 0;
        @(negedge clk); rdy = 1'b1; result = 14'h0155;
        @(negedge clk); rdy = 1'b0;
        n = 1;
        while (n < 6 && !(strobe_oe && !strobe_n)) begin
            @(negedge clk); n++;
        end
        check(n <= 3, "R9 launch latency", n, 3);
        wait_frames(nframes + 1);
    endtask

    task automatic t_free();
        int base;
        clk_mode = 1'b1;
        repeat (4) @(negedge clk);
        clear_errs();
        repeat (10) @(negedge clk);
        check(err_free == 0 && sclk_oe === 1, "R2 idle free clock", err_free, 0);
        check(strobe_oe === 1 && strobe_n === 1, "R11 strobe driven high idle",
              {strobe_oe, strobe_n}, 2'b11);
        base = nframes;
        pulse(14'h2A5C);
        wait_frames(base + 1);
        check(fword[base] === 14'h2A5C, "R5 word free mode", fword[base], 14'h2A5C);
        check(err_free == 0, "R2 clock during frame", err_free, 0);
        check(err_oe == 0 && err_chg == 0, "R7 R6 free mode", err_oe + err_chg, 0);
        clk_mode = 1'b0;
        repeat (4) @(negedge clk);
        clear_errs();
        repeat (6) @(negedge clk);
        check(err_gate == 0 && sclk_oe === 0, "R3 back to gated", err_gate, 0);
    endtask

    task automatic t_queue();
        int base = nframes;
        clear_errs();
        pulse(14'h1234);
        while (!(strobe_oe && !strobe_n)) @(negedge clk);
        repeat (5) @(negedge clk);
        pulse(14'h0F0F);
        repeat (4) @(negedge clk);
        pulse(14'h3C3A);
        wait_frames(base + 2);
        check(fword[base] === 14'h1234, "R8 first frame intact", fword[base], 14'h1234);
        check(flen[base] == 2 * W, "R8 first frame length", flen[base], 2 * W);
        check(fword[base+1] === 14'h3C3A, "R8 latest word sent", fword[base+1], 14'h3C3A);
        check(fgap[base+1] >= 1, "R8 strobe high gap", fgap[base+1], 1);
        check(nframes == base + 2, "R8 frame count", nframes - base, 2);
        check(err_oe == 0 && err_gate == 0, "R7 R3 queued", err_oe + err_gate, 0);
    endtask

    initial begin
        t_reset();
        t_word(14'h2000);
        t_word(14'h1FFF);
        t_word(14'h0000);
        t_word(14'h3FFF);
        t_word(14'h2AAA);
        t_latency();
        t_free();
        t_queue();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule